// File: doc/BRIEF.md
# Oversampling UART Receiver with Majority Voting

This block recovers asynchronous serial characters from a single RX line. The line is sampled on a sample-enable strobe that runs at sixteen times the bit rate. A falling edge on the line while the receiver is idle starts a sample counter. Three samples taken around the middle of the start bit then confirm or reject it. Every later bit takes the majority value of its three centre samples, so one bad sample inside a bit has no effect.

The frame format is chosen at run time: five to nine data bits, parity none, even or odd, and one or two stop bits. A finished character goes into a one-word buffer. Its frame and parity status travel with it in that buffer, together with an overrun status. A read strobe releases the word. Clearing the receive enable flushes the buffer. An optional address filter drops every frame whose last data bit is 0.

Top module: `uart_rx_ovs`

## Requirements
- R1: After reset, rxc_o, data_o, bit9_o, frame_err_o, parity_err_o and overrun_o are all 0.
- R2: While idle, a 1-to-0 change of the synchronized line on a sample strobe is sample 1 of a start bit. Samples 8, 9 and 10 are voted. A majority of 0 accepts the start bit. A majority of 1 returns the receiver to idle, and nothing is buffered.
- R3: Each data, parity and stop bit takes the 2-of-3 majority of its samples 8, 9 and 10. A single inverted sample among them does not change the bit.
- R4: data_bits_i selects the length: codes 0, 1, 2 and 3 give 5, 6, 7 and 8 bits, code 7 gives 9 bits, and other codes give 8 bits. The first bit received is bit 0. The word is right-aligned in {bit9_o, data_o}, and positions above the length read 0.
- R5: parity_mode_i 2'b10 selects even parity and 2'b11 selects odd parity. With either, parity_err_o is set with the word when the data ones plus the parity bit give a count of the wrong sense. With 2'b00 or 2'b01 no parity bit is expected and parity_err_o stays 0.
- R6: frame_err_o is set with the word when the first stop bit is voted 0. With two_stop_i set, the second stop bit is consumed but never checked.
- R7: When a start bit is accepted while rxc_o is 1, overrun_o becomes 1. The buffered word is kept, and the new frame is discarded.
- R8: rxc_o is 1 while an unread word is buffered. A one-cycle rd_i pulse clears rxc_o, frame_err_o, parity_err_o and overrun_o.
- R9: While rx_en_i is 0, the buffer is flushed: rxc_o, all error outputs and data_o read 0, and line activity is ignored.
- R10: With mpm_i set, a frame whose last data bit is 0 is discarded. A frame whose last data bit is 1 is buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Sample strobe, 16 per bit time |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| rx_en_i | input | 1 | Receive enable; low flushes the buffer |
| data_bits_i | input | 3 | Character length code |
| parity_mode_i | input | 2 | Parity selection |
| two_stop_i | input | 1 | Expect two stop bits |
| mpm_i | input | 1 | Address filter enable |
| rd_i | input | 1 | Read strobe for the buffered word |
| data_o | output | 8 | Low eight bits of the buffered word |
| bit9_o | output | 1 | Ninth bit of the buffered word |
| rxc_o | output | 1 | Unread word present |
| frame_err_o | output | 1 | Stop-bit error of the buffered word |
| parity_err_o | output | 1 | Parity error of the buffered word |
| overrun_o | output | 1 | A start bit was accepted while the word was unread |

## Verification
Random characters are sent in every length, parity and stop-bit setting. Some carry a flipped parity bit, a low first stop bit, or one inverted sample at position 8, 9 or 10 of every bit. The inverted sample separates true voting from single-point sampling. The flipped bits separate the two parity senses and the two stop-bit checks. Directed cases cover the rest. Low pulses of six and eight samples must be rejected as starts. A low second stop bit must pass unchecked. Further cases cover back-to-back frames with no read between them, a flush by the enable, and address filtering of 9-bit frames.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned WORD_W = 9;

  typedef enum logic [2:0] {
    ST_HUNT, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
  } rx_state_e;

  function automatic logic [3:0] frame_len(input logic [2:0] code);
    case (code)
      3'd0: frame_len = 4'd5;
      3'd1: frame_len = 4'd6;
      3'd2: frame_len = 4'd7;
      3'd7: frame_len = 4'd9;
      default: frame_len = 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_voter.sv
module uart_rx_voter #(
  parameter int unsigned OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  input  logic run_i,
  input  logic rx_i,
  output logic vote_o,
  output logic bit_o
);
  localparam int unsigned CW = $clog2(OVS);
  localparam logic [CW-1:0] S_A = CW'(OVS / 2);
  localparam logic [CW-1:0] S_B = CW'(OVS / 2 + 1);
  localparam logic [CW-1:0] S_C = CW'(OVS / 2 + 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] idx;
  logic s_a_q, s_b_q;

  // idx is the 1-based number of the sample taken on this strobe
  assign idx = cnt_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      s_a_q <= 1'b1;
      s_b_q <= 1'b1;
    end else if (tick_i) begin
      if (start_i)    cnt_q <= CW'(1);
      else if (run_i) cnt_q <= idx;
      if (run_i && idx == S_A) s_a_q <= rx_i;
      if (run_i && idx == S_B) s_b_q <= rx_i;
    end
  end

  assign vote_o = tick_i && run_i && !start_i && (idx == S_C);
  assign bit_o  = (s_a_q & s_b_q) | (s_a_q & rx_i) | (s_b_q & rx_i);
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         fe_i,
  input  logic         pe_i,
  input  logic         ovr_set_i,
  input  logic         rd_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         fe_o,
  output logic         pe_o,
  output logic         ovr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
      fe_o   <= 1'b0;
      pe_o   <= 1'b0;
      ovr_o  <= 1'b0;
    end else if (flush_i) begin
      data_o <= '0;
      full_o <= 1'b0;
      fe_o   <= 1'b0;
      pe_o   <= 1'b0;
      ovr_o  <= 1'b0;
    end else if (wr_i) begin
      data_o <= wdata_i;
      full_o <= 1'b1;
      fe_o   <= fe_i;
      pe_o   <= pe_i;
      ovr_o  <= 1'b0;
    end else if (rd_i) begin
      full_o <= 1'b0;
      fe_o   <= 1'b0;
      pe_o   <= 1'b0;
      ovr_o  <= 1'b0;
    end else if (ovr_set_i) begin
      ovr_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_ovs.sv
module uart_rx_ovs
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS       = 16,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic       rx_en_i,
  input  logic [2:0] data_bits_i,
  input  logic [1:0] parity_mode_i,
  input  logic       two_stop_i,
  input  logic       mpm_i,
  input  logic       rd_i,
  output logic [7:0] data_o,
  output logic       bit9_o,
  output logic       rxc_o,
  output logic       frame_err_o,
  output logic       parity_err_o,
  output logic       overrun_o
);
  rx_state_e         state_q;
  logic [3:0]        bit_idx_q;
  logic [WORD_W-1:0] shreg_q;
  logic              par_acc_q, pe_q, addr_q, rx_prev_q;
  logic              rx_s, start_edge, busy, vote, vote_bit;
  logic              frame_done, keep, wr, ovr_set;
  logic [3:0]        n_bits;
  logic [WORD_W-1:0] buf_data;

  uart_rx_sync #(.STAGES(SYNC_STGS), .RST_VAL(1'b1)) u_sync (
    .clk_i, .rst_ni, .d_i(rx_i), .q_o(rx_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rx_prev_q <= 1'b1;
    else if (tick_i) rx_prev_q <= rx_s;
  end

  assign busy       = (state_q != ST_HUNT);
  assign start_edge = rx_en_i && tick_i && !busy && rx_prev_q && !rx_s;
  assign n_bits     = frame_len(data_bits_i);

  uart_rx_voter #(.OVS(OVS)) u_voter (
    .clk_i, .rst_ni, .tick_i,
    .start_i(start_edge), .run_i(busy), .rx_i(rx_s),
    .vote_o(vote), .bit_o(vote_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_HUNT;
      bit_idx_q <= '0;
      shreg_q   <= '0;
      par_acc_q <= 1'b0;
      pe_q      <= 1'b0;
      addr_q    <= 1'b0;
    end else if (!rx_en_i) begin
      state_q <= ST_HUNT;
    end else if (start_edge) begin
      state_q <= ST_START;
    end else if (vote) begin
      unique case (state_q)
        ST_START: begin
          if (!vote_bit) begin
            state_q   <= ST_DATA;
            bit_idx_q <= '0;
            shreg_q   <= '0;
            par_acc_q <= 1'b0;
            pe_q      <= 1'b0;
          end else begin
            state_q <= ST_HUNT;   // false start
          end
        end
        ST_DATA: begin
          shreg_q[bit_idx_q] <= vote_bit;
          par_acc_q          <= par_acc_q ^ vote_bit;
          if (bit_idx_q == n_bits - 4'd1) begin
            addr_q  <= vote_bit;
            state_q <= parity_mode_i[1] ? ST_PAR : ST_STOP1;
          end else begin
            bit_idx_q <= bit_idx_q + 4'd1;
          end
        end
        ST_PAR: begin
          pe_q    <= par_acc_q ^ vote_bit ^ parity_mode_i[0];
          state_q <= ST_STOP1;
        end
        ST_STOP1: state_q <= two_stop_i ? ST_STOP2 : ST_HUNT;
        ST_STOP2: state_q <= ST_HUNT;     // second stop never checked
        default:  state_q <= ST_HUNT;
      endcase
    end
  end

  assign frame_done = rx_en_i && vote && (state_q == ST_STOP1);
  assign keep       = !mpm_i || addr_q;
  assign wr         = frame_done && keep && (!rxc_o || rd_i);
  assign ovr_set    = rx_en_i && vote && (state_q == ST_START) && !vote_bit && rxc_o && !rd_i;

  uart_rx_buf #(.W(WORD_W)) u_buf (
    .clk_i, .rst_ni,
    .flush_i(!rx_en_i), .wr_i(wr), .wdata_i(shreg_q),
    .fe_i(!vote_bit), .pe_i(pe_q), .ovr_set_i(ovr_set), .rd_i,
    .data_o(buf_data), .full_o(rxc_o),
    .fe_o(frame_err_o), .pe_o(parity_err_o), .ovr_o(overrun_o)
  );

  assign data_o = buf_data[7:0];
  assign bit9_o = buf_data[8];
endmodule

// File: rtl/uart_rx_ovs_chk.sv
module uart_rx_ovs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_en_i,
  input logic [2:0] data_bits_i,
  input logic [1:0] parity_mode_i,
  input logic       mpm_i,
  input logic       rd_i,
  input logic [7:0] data_o,
  input logic       bit9_o,
  input logic       rxc_o,
  input logic       frame_err_o,
  input logic       parity_err_o,
  input logic       overrun_o
);
  assert_flags_need_word_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rxc_o |-> (!frame_err_o && !parity_err_o && !overrun_o));

  assert_word_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxc_o && !rd_i && rx_en_i) |=> rxc_o);

  assert_flush_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> (!rxc_o && data_o == 8'h00 && !bit9_o && !overrun_o));

  assert_overrun_on_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> ($past(rxc_o) && rxc_o));

  assert_no_parity_err_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(parity_err_o) |-> $past(parity_mode_i[1]));

  assert_short_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rxc_o) && $past(data_bits_i) == 3'd0) |-> (data_o[7:5] == 3'b000 && !bit9_o));

  assert_addr_filter_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rxc_o) && $past(mpm_i) && $past(data_bits_i) == 3'd7) |-> bit9_o);
endmodule

bind uart_rx_ovs uart_rx_ovs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_en_i(rx_en_i), .data_bits_i(data_bits_i),
  .parity_mode_i(parity_mode_i), .mpm_i(mpm_i), .rd_i(rd_i), .data_o(data_o),
  .bit9_o(bit9_o), .rxc_o(rxc_o), .frame_err_o(frame_err_o),
  .parity_err_o(parity_err_o), .overrun_o(overrun_o)
);

// File: tb/sim_uart_rx_ovs.sv
`timescale 1ns/1ps
module sim_uart_rx_ovs;
  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rx = 1'b1, rx_en = 1'b1;
  logic [2:0] dbits = 3'd3;
  logic [1:0] pmode = 2'b00;
  logic       two_stop = 1'b0, mpm = 1'b0, rd = 1'b0;
  logic [7:0] data_o;
  logic       bit9_o, rxc_o, fe_o, pe_o, ovr_o;
  logic [1:0] tdiv = 2'd0;
  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tdiv <= tdiv + 2'd1;
    tick <= (tdiv == 2'd3);
  end

  uart_rx_ovs u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rx_i(rx), .rx_en_i(rx_en),
    .data_bits_i(dbits), .parity_mode_i(pmode), .two_stop_i(two_stop),
    .mpm_i(mpm), .rd_i(rd), .data_o(data_o), .bit9_o(bit9_o), .rxc_o(rxc_o),
    .frame_err_o(fe_o), .parity_err_o(pe_o), .overrun_o(ovr_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int len_of(input logic [2:0] code);
    case (code)
      3'd0: return 5;
      3'd1: return 6;
      3'd2: return 7;
      3'd7: return 9;
      default: return 8;
    endcase
  endfunction

  function automatic logic [8:0] mask_of(input int n);
    return 9'((1 << n) - 1);
  endfunction

  task automatic sample(input logic v);
    rx = v;
    do @(posedge clk); while (!tick);
    @(negedge clk);
  endtask

  task automatic send_bit(input logic v, input logic [15:0] gl);
    for (int i = 0; i < 16; i++) sample(v ^ gl[i]);
  endtask

  task automatic send_frame(input logic [8:0] d, input logic flip_par, input logic stop1,
                            input logic stop2, input logic [15:0] gl);
    int n;
    logic p;
    n = len_of(dbits);
    send_bit(1'b0, gl);
    for (int i = 0; i < n; i++) send_bit(d[i], gl);
    if (pmode[1]) begin
      p = (^(d & mask_of(n))) ^ pmode[0] ^ flip_par;
      send_bit(p, gl);
    end
    send_bit(stop1, gl);
    if (two_stop) send_bit(stop2, gl);
    send_bit(1'b1, 16'h0);
  endtask

  task automatic do_read();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_word(input string req, input logic [8:0] d, input logic fe,
                            input logic pe, input logic ov);
    logic [8:0] e;
    e = d & mask_of(len_of(dbits));
    chk({req, " rxc"}, rxc_o, 1'b1);
    chk({req, " data"}, data_o, e[7:0]);
    chk({req, " bit9"}, bit9_o, e[8]);
    chk({req, " frame_err"}, fe_o, fe);
    chk({req, " parity_err"}, pe_o, pe);
    chk({req, " overrun"}, ovr_o, ov);
  endtask

  task automatic check_empty(input string req);
    chk({req, " rxc"}, rxc_o, 1'b0);
    chk({req, " flags"}, {fe_o, pe_o, ovr_o}, 3'b000);
  endtask

  initial begin
    void'($urandom(32'h1bad5eed));
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1 rxc", rxc_o, 1'b0);
    chk("R1 data", {bit9_o, data_o}, 9'h000);
    chk("R1 flags", {fe_o, pe_o, ovr_o}, 3'b000);
    rst_n = 1'b1;
    send_bit(1'b1, 16'h0);

    // R2: six and eight low samples are rejected as starts
    for (int i = 0; i < 6; i++) sample(1'b0);
    send_bit(1'b1, 16'h0);
    send_bit(1'b1, 16'h0);
    check_empty("R2 short6");
    for (int i = 0; i < 8; i++) sample(1'b0);
    send_bit(1'b1, 16'h0);
    send_bit(1'b1, 16'h0);
    check_empty("R2 short8");

    // R4: 5-bit frame, right-aligned
    dbits = 3'd0;
    send_frame(9'h1F6, 1'b0, 1'b1, 1'b1, 16'h0);
    check_word("R4 five", 9'h1F6, 1'b0, 1'b0, 1'b0);
    do_read();
    check_empty("R8 read");

    // R6: second stop low is not checked, first stop low is
    dbits = 3'd3; two_stop = 1'b1;
    send_frame(9'h0C3, 1'b0, 1'b1, 1'b0, 16'h0);
    check_word("R6 stop2 low", 9'h0C3, 1'b0, 1'b0, 1'b0);
    do_read();
    send_frame(9'h03C, 1'b0, 1'b0, 1'b1, 16'h0);
    check_word("R6 stop1 low", 9'h03C, 1'b1, 1'b0, 1'b0);
    do_read();
    two_stop = 1'b0;

    // R7: second frame while unread
    send_frame(9'h0A1, 1'b0, 1'b1, 1'b1, 16'h0);
    send_frame(9'h05E, 1'b0, 1'b1, 1'b1, 16'h0);
    check_word("R7 overrun", 9'h0A1, 1'b0, 1'b0, 1'b1);
    do_read();
    check_empty("R7 R8 after read");

    // R9: flush, and frames ignored while disabled
    send_frame(9'h077, 1'b0, 1'b0, 1'b1, 16'h0);
    @(negedge clk) rx_en = 1'b0;
    repeat (2) @(negedge clk);
    check_empty("R9 flush");
    chk("R9 data", {bit9_o, data_o}, 9'h000);
    send_frame(9'h099, 1'b0, 1'b1, 1'b1, 16'h0);
    check_empty("R9 ignored");
    @(negedge clk) rx_en = 1'b1;
    send_bit(1'b1, 16'h0);
    send_frame(9'h042, 1'b0, 1'b1, 1'b1, 16'h0);
    check_word("R9 reenabled", 9'h042, 1'b0, 1'b0, 1'b0);
    do_read();

    // R10: address filter on 9-bit frames
    dbits = 3'd7; mpm = 1'b1;
    send_frame(9'h0A5, 1'b0, 1'b1, 1'b1, 16'h0);
    check_empty("R10 data frame dropped");
    send_frame(9'h15A, 1'b0, 1'b1, 1'b1, 16'h0);
    check_word("R10 address frame", 9'h15A, 1'b0, 1'b0, 1'b0);
    do_read();
    mpm = 1'b0;

    // R3 R4 R5 R6: random formats, injected errors and single-sample glitches
    for (int k = 0; k < 30; k++) begin
      logic [8:0]  d;
      logic [15:0] gl;
      logic        flip, s1, s2;
      int          c, g;
      c = int'($urandom % 5);
      dbits = (c == 4) ? 3'd7 : 3'(c);
      pmode = 2'($urandom % 4);
      two_stop = 1'($urandom % 2);
      d = 9'($urandom);
      flip = pmode[1] && ($urandom % 4 == 0);
      s1 = ($urandom % 5 != 0);
      s2 = 1'($urandom % 2);
      g = int'($urandom % 4);
      gl = (g == 0) ? 16'h0 : 16'(1 << (6 + g));
      send_frame(d, flip, s1, s2, gl);
      check_word("R3 R4 R5 R6 random", d, !s1, flip, 1'b0);
      do_read();
      check_empty("R8 random read");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule